// File: doc/BRIEF.md
# Multi-Bridge PCM Conference Summer

This block mixes linear voice samples for a set of independent conference bridges that share one pool of party slots. Each party slot is configured by a control word (attenuation code, noise-suppression field) and a bridge number. During a frame, samples arrive one at a time on a valid-strobed port. Each sample is scaled down by its party's attenuation in 1 dB steps and added into that party's bridge total and into the party's own running contribution.

A frame-end strobe closes the frame. In the same edge every bridge total is clipped to the 14-bit two's-complement range, and each party receives its bridge's clipped total minus its own contribution, so nobody hears their own voice. Any bridge whose total left the 14-bit range raises a sticky per-bridge overflow flag, which is cleared by writing one to it. It also raises a one-cycle interrupt pulse. A readback word per party echoes its control fields and shows whether a tone is currently being injected into that party's bridge.

Top module: `conf_summer`

## Requirements
- R1: A party's contribution is floor(sample * G(k) / 1024), where k is the 5-bit code in bits 7..3 of its control word and G(k) = round(1024 * 10^(-k/20)). Code 0 gives unity gain.
- R2: At frame end, each bridge total (bridge field value 0..4) is the sum of the contributions strobed during the frame by parties assigned to that bridge. A party whose bridge field is 5..7 is idle: it adds to no bridge and its output is 0.
- R3: The cycle after the frame_end cycle, out_valid is high for exactly one cycle. Each active party's 14-bit output slice p of out_smp then holds sat14(clipped bridge total - the party's own contributions). The outputs hold until the next frame end.
- R4: A bridge total above 8191 is clipped to 8191, and one below -8192 is clipped to -8192, before the per-party subtraction.
- R5: Bit b of ovf_flags is set at a frame end where bridge b's total fell outside -8192..8191. It stays set until a cycle in which ovf_clr bit b is 1. When a set and a clear meet in the same cycle, the set wins.
- R6: ovf_stat is the OR of ovf_flags. irq pulses for one cycle, in the cycle after a frame end at which at least one bridge overflowed.
- R7: Readback word p carries control bits 7..3 in bits 7..3 and control bits 1..0 (noise-suppression field) in bits 1..0. Bit 2 is the tone_on bit of the party's bridge, or 0 for an idle party. The noise-suppression field has no effect on any sum.
- R8: After reset, out_valid, all outputs, ovf_flags, ovf_stat and irq are 0, and the accumulators are empty.
- R9: A sample strobed in the same cycle as frame_end counts toward the next frame, not the closing one.
- R10: A party that sends no sample in a frame contributes 0 and receives its full clipped bridge total. A party that sends more than one sample has all of them summed as its own contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_party | input | 4 | Party slot of the strobed sample |
| smp_data | input | 14 | Linear two's-complement sample |
| frame_end | input | 1 | Closes the current frame |
| party_ctrl | input | 120 | Control word per party, 8 bits each |
| party_bridge | input | 45 | Bridge number per party, 3 bits each |
| tone_on | input | 5 | Tone injection active, per bridge |
| ovf_clr | input | 5 | Write-one-to-clear of overflow flags |
| out_valid | output | 1 | Output samples updated |
| out_smp | output | 210 | Mixed output per party, 14 bits each |
| party_rd | output | 120 | Readback word per party |
| ovf_flags | output | 5 | Sticky overflow flag per bridge |
| ovf_stat | output | 1 | Any bridge overflowed |
| irq | output | 1 | Overflow interrupt pulse |

## Verification
Mixed outputs, overflow flags and the interrupt all come from registers loaded at the frame_end edge. They are due one cycle after the frame_end cycle. The bench raises frame_end at a falling edge and compares these results at the next falling edge. One falling edge later it confirms that out_valid and irq have dropped. A clear-only write is checked at the falling edge after the one that drove it. Readback words are combinational, so they are compared at the falling edge that follows a configuration change.

// File: rtl/conf_pkg.sv
// Shared constants and the attenuation gain table for the conference summer.
// Assumes a 5-bit attenuation code and a 10-bit fractional gain.
package conf_pkg;
    localparam int CTRL_W    = 8;   // control word width
    localparam int ATT_LSB   = 3;   // attenuation field low bit
    localparam int ATT_W     = 5;   // attenuation field width
    localparam int NS_W      = 2;   // noise-suppression field width
    localparam int GAIN_FRAC = 10;  // fraction bits of the gain multiplier

    // Gain for a given dB step, as round(1024 * 10^(-code/20)).
    function automatic logic [GAIN_FRAC:0] gain_q(input logic [ATT_W-1:0] code);
        case (code)
            5'd0:  gain_q = 11'd1024;  5'd1:  gain_q = 11'd913;
            5'd2:  gain_q = 11'd813;   5'd3:  gain_q = 11'd725;
            5'd4:  gain_q = 11'd646;   5'd5:  gain_q = 11'd576;
            5'd6:  gain_q = 11'd513;   5'd7:  gain_q = 11'd457;
            5'd8:  gain_q = 11'd408;   5'd9:  gain_q = 11'd363;
            5'd10: gain_q = 11'd324;   5'd11: gain_q = 11'd289;
            5'd12: gain_q = 11'd257;   5'd13: gain_q = 11'd229;
            5'd14: gain_q = 11'd204;   5'd15: gain_q = 11'd182;
            5'd16: gain_q = 11'd162;   5'd17: gain_q = 11'd145;
            5'd18: gain_q = 11'd129;   5'd19: gain_q = 11'd115;
            5'd20: gain_q = 11'd102;   5'd21: gain_q = 11'd91;
            5'd22: gain_q = 11'd81;    5'd23: gain_q = 11'd72;
            5'd24: gain_q = 11'd65;    5'd25: gain_q = 11'd58;
            5'd26: gain_q = 11'd51;    5'd27: gain_q = 11'd46;
            5'd28: gain_q = 11'd41;    5'd29: gain_q = 11'd36;
            5'd30: gain_q = 11'd32;    default: gain_q = 11'd29;
        endcase
    endfunction
endpackage

// File: rtl/conf_atten.sv
// Combinational attenuator: scales a signed sample by the table gain using
// shift-and-add over the set bits of the gain, then floors the result.
// Assumes gain <= 1.0, so the result always fits the sample width.
module conf_atten
    import conf_pkg::*;
#(
    parameter int SMP_W = 14
) (
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic [ATT_W-1:0]        code,
    output logic signed [SMP_W-1:0] smp_out
);
    localparam int PW = SMP_W + GAIN_FRAC + 1;

    logic [GAIN_FRAC:0]     gain;
    logic signed [PW-1:0]   ext;
    logic signed [PW-1:0]   prod;

    // Sum shifted copies of the sample for every set gain bit.
    always_comb begin
        gain = gain_q(code);
        ext  = PW'(smp_in);
        prod = '0;
        for (int i = 0; i <= GAIN_FRAC; i++) begin
            if (gain[i]) prod = prod + (ext <<< i);
        end
        smp_out = prod[GAIN_FRAC +: SMP_W];
    end
endmodule

// File: rtl/conf_lane_acc.sv
// Bank of N frame accumulators selected by an index. A frame_end restarts
// every lane; an add in that same cycle seeds the new frame.
// Assumes indices >= N select no lane.
module conf_lane_acc #(
    parameter int N     = 5,
    parameter int IDX_W = 3,
    parameter int SMP_W = 14,
    parameter int ACC_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_end,
    input  logic                        add_en,
    input  logic [IDX_W-1:0]            add_idx,
    input  logic signed [SMP_W-1:0]     add_val,
    output logic [N-1:0][ACC_W-1:0]     lane_sum
);
    logic signed [ACC_W-1:0] ext;
    assign ext = ACC_W'(add_val);

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic                    hit;
        logic signed [ACC_W-1:0] acc_q;
        assign hit = add_en && (add_idx == IDX_W'(i));

        // Accumulate hits; restart at frame end.
        always_ff @(posedge clk) begin
            if (!rst_n)         acc_q <= '0;
            else if (frame_end) acc_q <= hit ? ext : '0;
            else if (hit)       acc_q <= acc_q + ext;
        end
        assign lane_sum[i] = acc_q;
    end
endmodule

// File: rtl/conf_result.sv
// Frame-close stage: clips each bridge total to the sample range, forms
// each party's output as clipped total minus its own share, and keeps
// sticky per-bridge overflow flags plus an interrupt pulse.
// Assumes party sums fit ACC_W bits.
module conf_result #(
    parameter int PARTIES = 15,
    parameter int BRIDGES = 5,
    parameter int BR_W    = 3,
    parameter int SMP_W   = 14,
    parameter int ACC_W   = 20
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frame_end,
    input  logic [BRIDGES-1:0]             ovf_clr,
    input  logic [BRIDGES-1:0][ACC_W-1:0]  bridge_sum,
    input  logic [PARTIES-1:0][ACC_W-1:0]  party_sum,
    input  logic [PARTIES-1:0][BR_W-1:0]   party_br,
    output logic                           out_valid,
    output logic [PARTIES-1:0][SMP_W-1:0]  out_smp,
    output logic [BRIDGES-1:0]             ovf_flags,
    output logic                           irq
);
    localparam int DW = ACC_W + 1;
    localparam logic signed [DW-1:0] MAXV = DW'((2 ** (SMP_W - 1)) - 1);
    localparam logic signed [DW-1:0] MINV = -DW'(2 ** (SMP_W - 1));

    logic signed [DW-1:0]        clip_v [BRIDGES];
    logic [BRIDGES-1:0]          ovf_now;
    logic [PARTIES-1:0][SMP_W-1:0] mix_d;

    // Clip each bridge total and detect range violations.
    always_comb begin
        for (int b = 0; b < BRIDGES; b++) begin
            logic signed [DW-1:0] s;
            s = DW'($signed(bridge_sum[b]));
            ovf_now[b] = (s > MAXV) || (s < MINV);
            clip_v[b]  = (s > MAXV) ? MAXV : ((s < MINV) ? MINV : s);
        end
    end

    // Per-party mix: clipped bridge total minus own share, saturated.
    always_comb begin
        for (int p = 0; p < PARTIES; p++) begin
            logic signed [DW-1:0] d;
            logic signed [DW-1:0] sel;
            sel = '0;
            for (int b = 0; b < BRIDGES; b++) begin
                if (party_br[p] == BR_W'(b)) sel = clip_v[b];
            end
            d = sel - DW'($signed(party_sum[p]));
            if (party_br[p] >= BR_W'(BRIDGES)) mix_d[p] = '0;
            else if (d > MAXV)                 mix_d[p] = MAXV[SMP_W-1:0];
            else if (d < MINV)                 mix_d[p] = MINV[SMP_W-1:0];
            else                               mix_d[p] = d[SMP_W-1:0];
        end
    end

    // Register outputs and the valid pulse at frame close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_smp   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= frame_end;
            if (frame_end) out_smp <= mix_d;
        end
    end

    // Sticky flags, write-one-to-clear, set wins; interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flags <= '0;
            irq       <= 1'b0;
        end else begin
            ovf_flags <= (ovf_flags & ~ovf_clr) | (frame_end ? ovf_now : '0);
            irq       <= frame_end && (|ovf_now);
        end
    end
endmodule

// File: rtl/conf_summer.sv
// Conference summer top: attenuates each strobed sample, accumulates it
// per bridge and per party, and closes the frame into mixed outputs.
// Assumes configuration is steady within a frame.
module conf_summer
    import conf_pkg::*;
#(
    parameter int PARTIES = 15,
    parameter int BRIDGES = 5,
    parameter int SMP_W   = 14,
    parameter int PI_W    = $clog2(PARTIES + 1),
    parameter int BR_W    = $clog2(BRIDGES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [PI_W-1:0]            smp_party,
    input  logic [SMP_W-1:0]           smp_data,
    input  logic                       frame_end,
    input  logic [PARTIES*CTRL_W-1:0]  party_ctrl,
    input  logic [PARTIES*BR_W-1:0]    party_bridge,
    input  logic [BRIDGES-1:0]         tone_on,
    input  logic [BRIDGES-1:0]         ovf_clr,
    output logic                       out_valid,
    output logic [PARTIES*SMP_W-1:0]   out_smp,
    output logic [PARTIES*CTRL_W-1:0]  party_rd,
    output logic [BRIDGES-1:0]         ovf_flags,
    output logic                       ovf_stat,
    output logic                       irq
);
    localparam int ACC_W = SMP_W + $clog2(PARTIES) + 2;

    logic [PARTIES-1:0][BR_W-1:0]   br_arr;
    logic [PARTIES-1:0][ATT_W-1:0]  att_arr;
    logic                           in_range;
    logic [PI_W-1:0]                pidx;
    logic signed [SMP_W-1:0]        att_smp;
    logic [BRIDGES-1:0][ACC_W-1:0]  bridge_sum;
    logic [PARTIES-1:0][ACC_W-1:0]  party_sum;
    logic [PARTIES-1:0][SMP_W-1:0]  mix_q;

    // Unpack per-party fields and build readback words.
    for (genvar p = 0; p < PARTIES; p++) begin : g_party
        assign br_arr[p]  = party_bridge[p*BR_W +: BR_W];
        assign att_arr[p] = party_ctrl[p*CTRL_W + ATT_LSB +: ATT_W];
        assign party_rd[p*CTRL_W +: CTRL_W] =
            {att_arr[p],
             (br_arr[p] < BR_W'(BRIDGES)) ? tone_on[br_arr[p]] : 1'b0,
             party_ctrl[p*CTRL_W +: NS_W]};
        assign out_smp[p*SMP_W +: SMP_W] = mix_q[p];
    end

    assign in_range = (smp_party < PI_W'(PARTIES));
    assign pidx     = in_range ? smp_party : '0;

    conf_atten #(.SMP_W(SMP_W)) atten_i (
        .smp_in  (smp_data),
        .code    (att_arr[pidx]),
        .smp_out (att_smp)
    );

    conf_lane_acc #(.N(BRIDGES), .IDX_W(BR_W), .SMP_W(SMP_W), .ACC_W(ACC_W)) bridge_acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .add_en    (smp_valid && in_range),
        .add_idx   (br_arr[pidx]),
        .add_val   (att_smp),
        .lane_sum  (bridge_sum)
    );

    conf_lane_acc #(.N(PARTIES), .IDX_W(PI_W), .SMP_W(SMP_W), .ACC_W(ACC_W)) party_acc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .add_en    (smp_valid && in_range),
        .add_idx   (pidx),
        .add_val   (att_smp),
        .lane_sum  (party_sum)
    );

    conf_result #(.PARTIES(PARTIES), .BRIDGES(BRIDGES), .BR_W(BR_W),
                  .SMP_W(SMP_W), .ACC_W(ACC_W)) result_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .ovf_clr    (ovf_clr),
        .bridge_sum (bridge_sum),
        .party_sum  (party_sum),
        .party_br   (br_arr),
        .out_valid  (out_valid),
        .out_smp    (mix_q),
        .ovf_flags  (ovf_flags),
        .irq        (irq)
    );

    assign ovf_stat = |ovf_flags;
endmodule

// File: rtl/conf_summer_chk.sv
// Assertion checker for the conference summer, bound to the top module.
module conf_summer_chk #(
    parameter int PARTIES = 15,
    parameter int BRIDGES = 5,
    parameter int SMP_W   = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     frame_end,
    input logic [BRIDGES-1:0]       ovf_clr,
    input logic                     out_valid,
    input logic [PARTIES*SMP_W-1:0] out_smp,
    input logic [BRIDGES-1:0]       ovf_flags,
    input logic                     ovf_stat,
    input logic                     irq
);
    // R3
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> out_valid);
    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> !out_valid);
    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(out_smp));
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ovf_flags) & ~$past(ovf_clr) & ~ovf_flags) == '0));
    // R5
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_end && ovf_clr == '0) |=> $stable(ovf_flags));
    // R6
    irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_stat);
    // R6
    irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> !irq);
endmodule

bind conf_summer conf_summer_chk #(.PARTIES(PARTIES), .BRIDGES(BRIDGES), .SMP_W(SMP_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .ovf_clr   (ovf_clr),
    .out_valid (out_valid),
    .out_smp   (out_smp),
    .ovf_flags (ovf_flags),
    .ovf_stat  (ovf_stat),
    .irq       (irq)
);

// File: tb/conf_summer_tb_top.sv
`timescale 1ns/1ps
module conf_summer_tb_top;
    localparam int NP = 15;
    localparam int NB = 5;
    localparam int SW = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [3:0]        smp_party = '0;
    logic [SW-1:0]     smp_data = '0;
    logic              frame_end = 1'b0;
    logic [NP*8-1:0]   party_ctrl = '0;
    logic [NP*3-1:0]   party_bridge = '0;
    logic [NB-1:0]     tone_on = '0;
    logic [NB-1:0]     ovf_clr = '0;
    logic              out_valid;
    logic [NP*SW-1:0]  out_smp;
    logic [NP*8-1:0]   party_rd;
    logic [NB-1:0]     ovf_flags;
    logic              ovf_stat;
    logic              irq;

    int checks = 0;
    int errors = 0;

    int       cfg_att [NP];
    int       cfg_ns  [NP];
    int       cfg_b2  [NP];
    int       cfg_br  [NP];
    int       own     [NP];
    int       tot     [NB];
    logic [NB-1:0] flags_m = '0;

    always #2.5 clk = ~clk;

    conf_summer dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_party(smp_party),
        .smp_data(smp_data), .frame_end(frame_end), .party_ctrl(party_ctrl),
        .party_bridge(party_bridge), .tone_on(tone_on), .ovf_clr(ovf_clr),
        .out_valid(out_valid), .out_smp(out_smp), .party_rd(party_rd),
        .ovf_flags(ovf_flags), .ovf_stat(ovf_stat), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int att_model(input int s, input int k);
        int g;
        g = int'($floor(1024.0 * $pow(10.0, -k / 20.0) + 0.5));
        return (s * g) >>> 10;
    endfunction

    function automatic int sat14(input int v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic int out_of(input int p);
        return int'($signed(out_smp[p*SW +: SW]));
    endfunction

    task automatic model_add(input int p, input int s);
        int a;
        a = att_model(s, cfg_att[p]);
        own[p] += a;
        if (cfg_br[p] < NB) tot[cfg_br[p]] += a;
    endtask

    // Drive configuration and check readback (R7).
    task automatic apply_cfg();
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            party_ctrl[p*8 +: 8]   = {cfg_att[p][4:0], cfg_b2[p][0], cfg_ns[p][1:0]};
            party_bridge[p*3 +: 3] = cfg_br[p][2:0];
        end
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            int tb;
            tb = (cfg_br[p] < NB) ? int'(tone_on[cfg_br[p]]) : 0;
            check("R7 readback", int'(party_rd[p*8 +: 8]),
                  (cfg_att[p] << 3) | (tb << 2) | cfg_ns[p]);
        end
    endtask

    task automatic send(input int p, input int s);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_party = p[3:0];
        smp_data  = s[SW-1:0];
        model_add(p, s);
    endtask

    // Close a frame, optionally with a clear and a carried sample (R9).
    task automatic close_frame(input logic [NB-1:0] clr, input bit carry,
                               input int cp, input int cs);
        int exp_out [NP];
        logic [NB-1:0] newov;
        @(negedge clk);
        smp_valid = carry;
        smp_party = cp[3:0];
        smp_data  = cs[SW-1:0];
        frame_end = 1'b1;
        ovf_clr   = clr;
        newov = '0;
        for (int b = 0; b < NB; b++) newov[b] = (tot[b] > 8191) || (tot[b] < -8192);
        for (int p = 0; p < NP; p++)
            exp_out[p] = (cfg_br[p] < NB) ? sat14(sat14(tot[cfg_br[p]]) - own[p]) : 0;
        flags_m = (flags_m & ~clr) | newov;
        for (int p = 0; p < NP; p++) own[p] = 0;
        for (int b = 0; b < NB; b++) tot[b] = 0;
        if (carry) model_add(cp, cs);
        @(negedge clk);
        frame_end = 1'b0;
        smp_valid = 1'b0;
        ovf_clr   = '0;
        check("R3 out_valid high", int'(out_valid), 1);
        for (int p = 0; p < NP; p++) check("R2/R3/R4 mix output", out_of(p), exp_out[p]);
        check("R5 ovf_flags", int'(ovf_flags), int'(flags_m));
        check("R6 ovf_stat", int'(ovf_stat), int'(|flags_m));
        check("R6 irq pulse", int'(irq), int'(|newov));
        @(negedge clk);
        check("R3 out_valid drops", int'(out_valid), 0);
        check("R6 irq drops", int'(irq), 0);
    endtask

    task automatic clear_only(input logic [NB-1:0] clr);
        @(negedge clk);
        ovf_clr = clr;
        flags_m = flags_m & ~clr;
        @(negedge clk);
        ovf_clr = '0;
        check("R5 clear", int'(ovf_flags), int'(flags_m));
        check("R6 stat after clear", int'(ovf_stat), int'(|flags_m));
    endtask

    task automatic idle_cfg();
        for (int p = 0; p < NP; p++) begin
            cfg_att[p] = 0; cfg_ns[p] = 0; cfg_b2[p] = 0; cfg_br[p] = 7;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int p = 0; p < NP; p++) own[p] = 0;
        for (int b = 0; b < NB; b++) tot[b] = 0;
        idle_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 out_valid", int'(out_valid), 0);
        check("R8 out_smp", int'(out_smp != '0), 0);
        check("R8 flags", int'(ovf_flags), 0);
        check("R8 stat", int'(ovf_stat), 0);
        check("R8 irq", int'(irq), 0);

        // R1 attenuation sweep: party 1 hears party 0 alone.
        for (int k = 0; k < 32; k++) begin
            idle_cfg();
            cfg_br[0] = 0; cfg_att[0] = k;
            cfg_br[1] = 0;
            apply_cfg();
            send(0, (k % 2 == 0) ? 8000 : -7777);
            close_frame('0, 1'b0, 0, 0);
            check("R1 gain step", own[0], 0);
        end

        // R4 positive and negative clipping on two bridges.
        idle_cfg();
        for (int p = 0; p < 3; p++) cfg_br[p] = 1;
        for (int p = 3; p < 6; p++) cfg_br[p] = 2;
        cfg_br[6] = 1;
        apply_cfg();
        for (int p = 0; p < 3; p++) send(p, 6000);
        for (int p = 3; p < 6; p++) send(p, -6000);
        close_frame('0, 1'b0, 0, 0);
        check("R4 listener gets clipped max", out_of(6), 8191);
        check("R5 bridges 1 and 2 flagged", int'(ovf_flags), 5'b00110);

        // R5 clear-only, then set wins over simultaneous clear.
        clear_only(5'b00010);
        for (int p = 0; p < 3; p++) send(p, 6000);
        close_frame(5'b00110, 1'b0, 0, 0);
        check("R5 set wins over clear", int'(ovf_flags[1]), 1);
        check("R5 cleared bridge 2", int'(ovf_flags[2]), 0);
        clear_only(5'b11111);

        // R10 lone speaker hears nothing, silent party hears all, duplicates sum.
        idle_cfg();
        cfg_br[4] = 3; cfg_att[4] = 6;
        cfg_br[5] = 3;
        cfg_br[7] = 4; cfg_br[8] = 4;
        apply_cfg();
        send(4, 4000);
        send(7, 1000);
        send(7, 1500);
        send(8, 200);
        close_frame('0, 1'b0, 0, 0);
        check("R10 lone speaker", out_of(4), 0);
        check("R10 silent listener", out_of(5), att_model(4000, 6));
        check("R10 duplicate own", out_of(7), 200);

        // R9 sample coinciding with frame_end lands in the next frame.
        send(5, 300);
        close_frame('0, 1'b1, 4, 2000);
        close_frame('0, 1'b0, 0, 0);
        check("R9 carried sample heard", out_of(5), att_model(2000, 6));

        // Random frames with tone and noise fields varied (R1..R7).
        for (int f = 0; f < 60; f++) begin
            int big;
            big = (f % 3 != 0);
            tone_on = NB'($urandom);
            for (int p = 0; p < NP; p++) begin
                cfg_att[p] = int'($urandom_range(31));
                cfg_ns[p]  = int'($urandom_range(3));
                cfg_b2[p]  = int'($urandom_range(1));
                cfg_br[p]  = int'($urandom_range(6));
            end
            apply_cfg();
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(3) != 0) begin
                    int s;
                    s = big ? int'($urandom_range(16383)) - 8192
                            : int'($urandom_range(2000)) - 1000;
                    send(p, s);
                    if ($urandom_range(7) == 0) send(p, s / 2);
                end
            end
            close_frame(NB'($urandom_range(31)) & {NB{f[0]}}, 1'b0, 0, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule